// File: doc/BRIEF.md
# VME Function Window Address Decoder

This block decides whether a bus access belongs to one of a small set of function windows. Each window has two words: a compare word and a mask word. The compare word holds the base address, the expected address modifier and a size-reload flag. The mask word holds the address mask and a sizing-capability flag. The address, the address modifier and the address strobe are registered at the block boundary before any decoding, so a changing address cannot race the match result. The block returns a one-hot hit per function and a single `fn_sel` flag that the bus slave uses to qualify its data acknowledge.

Configuration words enter through a valid/ready write port. `cfg_ready` is high only while no bus cycle is being decoded, meaning the registered strobe is high. A write offered with `cfg_valid` during a cycle waits, with its data held, until the strobe has been seen high again. Back-pressure therefore lasts exactly as long as the decoded cycle. A combinational read port returns any stored word.

A window whose sizing flag is set supports run-time resizing. A compare-word write with the reload flag set loads its compare bits into the mask and disables the window. A later compare-word write with the flag clear restores the window.

Top module: `vme_fn_decoder`

## Requirements
- R1: A hit appears on the second rising clock edge after `vme_as_n` is seen low: one edge registers the strobe and one edge registers the result. The decode uses the address and modifier sampled together with the strobe.
- R2: A window matches when `(addr[31:8] & mask) == (compare & mask)` and the access modifier equals the window's modifier field (compare word bits [7:2]).
- R3: The modifier comparison always applies. This holds for every window, including one whose mask word has the sizing flag (bit 2) set.
- R4: A window whose 24-bit mask is all zero never hits.
- R5: When several windows match, only the lowest-numbered one is reported, so `fn_hit` is one-hot or zero. `fn_sel` is high exactly when `fn_hit` is non-zero.
- R6: `fn_hit` holds its value while the strobe stays low, even if the address changes. It clears on the second edge after the strobe is seen high.
- R7: A mask-word write (`cfg_reg_sel`=1) stores mask bits [31:8] and the sizing flag from bit 2. The mask word reads back as {mask, 5'b0, sizing, 2'b0}, so the extra-decoder bit 0 always reads 0.
- R8: With the sizing flag set, a compare-word write with bit 1 set loads data[31:8] into the mask and leaves the compare bits, the modifier and the extended-modifier bit unchanged. It also sets the window's stored reload flag, and the window stops hitting. The compare word reads back as {compare, modifier, reload, xam}.
- R9: A later compare-word write with bit 1 clear stores the whole word, clears the reload flag and restores matching under the reloaded mask.
- R10: With the sizing flag clear, a compare-word write with bit 1 set stores the whole word, mask unchanged, and the window does not hit while the flag is set.
- R11: Synchronous reset clears every compare and mask word and every hit, and leaves `cfg_ready` high.
- R12: `cfg_ready` is low while the registered strobe is low. A write offered then takes no effect until it is accepted after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_addr | input | 32 | Access address |
| vme_am | input | 6 | Access address modifier |
| cfg_valid | input | 1 | Configuration write offered |
| cfg_ready | output | 1 | Configuration write accepted this edge when valid |
| cfg_reg_sel | input | 1 | 0 selects the compare word, 1 the mask word |
| cfg_fn | input | 2 | Target function index |
| cfg_data | input | 32 | Word to write |
| rd_fn | input | 2 | Function index to read |
| rd_reg_sel | input | 1 | 0 reads the compare word, 1 the mask word |
| rd_data | output | 32 | Read-back word |
| fn_hit | output | 4 | One-hot winning function |
| fn_sel | output | 1 | Any function selected |

## Verification
The hardest situation to reach is the sizing sequence. The bench must first set the sizing flag through a mask write, then send a compare write with the reload flag set. It then shows that the window is dark even for an address that matched before. Only after that does it write the original word back and show that matching resumes under the new, wider mask. Overlapping windows with equal modifiers are set up on purpose to exercise priority. A write is also held valid through an active strobe to show that back-pressure lasts for the whole cycle. A behavioural model runs beside the design and compares every output on every clock.

// File: rtl/vme_fn_pkg.sv
package vme_fn_pkg;
  localparam int ADDR_W  = 32;
  localparam int AM_W    = 6;
  localparam int CMP_LSB = 8;
  localparam int CMP_W   = ADDR_W - CMP_LSB;
  localparam int AM_LSB  = 2;
  localparam int RELOAD_BIT = 1;
  localparam int XAM_BIT    = 0;
  localparam int SIZING_BIT = 2;

  typedef struct packed {
    logic [CMP_W-1:0] cmp;
    logic [AM_W-1:0]  am;
    logic             reload;
    logic             xam;
    logic [CMP_W-1:0] mask;
    logic             sizing;
  } win_cfg_t;
endpackage

// File: rtl/vme_fn_cfg_regs.sv
module vme_fn_cfg_regs
  import vme_fn_pkg::*;
#(
  parameter int NUM_FN = 4,
  localparam int FN_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_is_mask,
  input  logic [FN_W-1:0]   wr_fn,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [FN_W-1:0]   rd_fn,
  input  logic              rd_is_mask,
  output logic [ADDR_W-1:0] rd_data,
  output win_cfg_t          cfg [NUM_FN]
);
  logic [4:0] unused_wr_bits;
  assign unused_wr_bits = wr_data[7:3];

  for (genvar g = 0; g < NUM_FN; g++) begin : g_win
    logic sel;
    assign sel = wr_en && (wr_fn == FN_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[g] <= '0;
      end else if (sel) begin
        if (wr_is_mask) begin
          cfg[g].mask   <= wr_data[ADDR_W-1:CMP_LSB];
          cfg[g].sizing <= wr_data[SIZING_BIT];
        end else if (wr_data[RELOAD_BIT] && cfg[g].sizing) begin
          cfg[g].mask   <= wr_data[ADDR_W-1:CMP_LSB];
          cfg[g].reload <= 1'b1;
        end else begin
          cfg[g].cmp    <= wr_data[ADDR_W-1:CMP_LSB];
          cfg[g].am     <= wr_data[AM_LSB+AM_W-1:AM_LSB];
          cfg[g].reload <= wr_data[RELOAD_BIT];
          cfg[g].xam    <= wr_data[XAM_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (rd_fn == FN_W'(i)) begin
        if (rd_is_mask)
          rd_data = {cfg[i].mask, 5'b0, cfg[i].sizing, 1'b0, 1'b0};
        else
          rd_data = {cfg[i].cmp, cfg[i].am, cfg[i].reload, cfg[i].xam};
      end
    end
  end
endmodule

// File: rtl/vme_fn_window_match.sv
module vme_fn_window_match
  import vme_fn_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [CMP_W-1:0]  addr_hi,
  input  logic [AM_W-1:0]   am,
  output logic              hit
);
  logic addr_ok, am_ok, mask_live;
  assign addr_ok   = ((addr_hi & cfg.mask) == (cfg.cmp & cfg.mask));
  assign am_ok     = (am == cfg.am);
  assign mask_live = |cfg.mask;
  assign hit       = addr_ok && am_ok && mask_live && !cfg.reload;
endmodule

// File: rtl/vme_fn_prio.sv
module vme_fn_prio #(
  parameter int N = 4
)(
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vme_fn_decoder.sv
module vme_fn_decoder
  import vme_fn_pkg::*;
#(
  parameter int NUM_FN = 4,
  localparam int FN_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              vme_as_n,
  input  logic [31:0]       vme_addr,
  input  logic [5:0]        vme_am,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_reg_sel,
  input  logic [FN_W-1:0]   cfg_fn,
  input  logic [31:0]       cfg_data,
  input  logic [FN_W-1:0]   rd_fn,
  input  logic              rd_reg_sel,
  output logic [31:0]       rd_data,
  output logic [NUM_FN-1:0] fn_hit,
  output logic              fn_sel
);
  logic              as_q, as_qq;
  logic [ADDR_W-1:0] addr_q;
  logic [AM_W-1:0]   am_q;
  logic [7:0]        unused_addr_lo;
  win_cfg_t          cfg [NUM_FN];
  logic [NUM_FN-1:0] raw_hit, win_onehot, hit_q;
  logic [NUM_FN-1:0] reload_vec, zmask_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_q   <= 1'b1;
      as_qq  <= 1'b1;
      addr_q <= '0;
      am_q   <= '0;
    end else begin
      as_q   <= vme_as_n;
      as_qq  <= as_q;
      addr_q <= vme_addr;
      am_q   <= vme_am;
    end
  end
  assign unused_addr_lo = addr_q[CMP_LSB-1:0];

  assign cfg_ready = as_q;

  vme_fn_cfg_regs #(.NUM_FN(NUM_FN)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_valid && cfg_ready),
    .wr_is_mask (cfg_reg_sel),
    .wr_fn      (cfg_fn),
    .wr_data    (cfg_data),
    .rd_fn      (rd_fn),
    .rd_is_mask (rd_reg_sel),
    .rd_data    (rd_data),
    .cfg        (cfg)
  );

  for (genvar g = 0; g < NUM_FN; g++) begin : g_match
    vme_fn_window_match u_match (
      .cfg     (cfg[g]),
      .addr_hi (addr_q[ADDR_W-1:CMP_LSB]),
      .am      (am_q),
      .hit     (raw_hit[g])
    );
    assign reload_vec[g] = cfg[g].reload;
    assign zmask_vec[g]  = ~|cfg[g].mask;
  end

  vme_fn_prio #(.N(NUM_FN)) u_prio (
    .req   (raw_hit),
    .grant (win_onehot)
  );

  always_ff @(posedge clk) begin
    if (rst)        hit_q <= '0;
    else if (as_q)  hit_q <= '0;
    else if (as_qq) hit_q <= win_onehot;
  end

  assign fn_hit = hit_q;
  assign fn_sel = |hit_q;
endmodule

// File: rtl/vme_fn_decoder_chk.sv
module vme_fn_decoder_chk #(
  parameter int NUM_FN = 4
)(
  input logic              clk,
  input logic              rst,
  input logic              as_q,
  input logic              as_qq,
  input logic [NUM_FN-1:0] fn_hit,
  input logic              fn_sel,
  input logic [NUM_FN-1:0] reload_vec,
  input logic [NUM_FN-1:0] zmask_vec
);
  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fn_hit));

  assert_rise_after_fall_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(fn_sel) |-> (!$past(as_q) && $past(as_qq)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $past(as_q) |-> (fn_hit == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(as_q) && !$past(as_qq)) |-> $stable(fn_hit));

  assert_reload_dark_R8: assert property (@(posedge clk) disable iff (rst)
    (fn_hit & reload_vec) == '0);

  assert_zero_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (fn_hit & zmask_vec) == '0);
endmodule

bind vme_fn_decoder vme_fn_decoder_chk #(.NUM_FN(NUM_FN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .as_q       (as_q),
  .as_qq      (as_qq),
  .fn_hit     (fn_hit),
  .fn_sel     (fn_sel),
  .reload_vec (reload_vec),
  .zmask_vec  (zmask_vec)
);

// File: tb/tb_vme_fn_decoder.sv
module tb_vme_fn_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vme_as_n = 1'b1;
  logic [31:0] vme_addr = '0;
  logic [5:0]  vme_am = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic        cfg_reg_sel = 1'b0;
  logic [1:0]  cfg_fn = '0;
  logic [31:0] cfg_data = '0;
  logic [1:0]  rd_fn = '0;
  logic        rd_reg_sel = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  fn_hit;
  logic        fn_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vme_fn_decoder dut (.*);

  // behavioural reference model
  logic [23:0] m_cmp [4];
  logic [5:0]  m_am  [4];
  logic        m_rl  [4];
  logic        m_xam [4];
  logic [23:0] m_mask[4];
  logic        m_sz  [4];
  logic        m_asq, m_asqq;
  logic [31:0] m_addr;
  logic [5:0]  m_acc_am;
  logic [3:0]  m_hit;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_cmp[i] = 0; m_am[i] = 0; m_rl[i] = 0; m_xam[i] = 0;
        m_mask[i] = 0; m_sz[i] = 0;
      end
      m_asq = 1; m_asqq = 1; m_addr = 0; m_acc_am = 0; m_hit = 0;
    end else begin
      if (m_asq) m_hit = 0;
      else if (m_asqq) begin
        m_hit = 0;
        for (int i = 3; i >= 0; i--)
          if (m_mask[i] != 0 && !m_rl[i] && m_acc_am == m_am[i] &&
              ((m_addr[31:8] & m_mask[i]) == (m_cmp[i] & m_mask[i])))
            m_hit = 4'(1 << i);
      end
      if (cfg_valid && m_asq) begin
        if (cfg_reg_sel) begin
          m_mask[cfg_fn] = cfg_data[31:8];
          m_sz[cfg_fn]   = cfg_data[2];
        end else if (cfg_data[1] && m_sz[cfg_fn]) begin
          m_mask[cfg_fn] = cfg_data[31:8];
          m_rl[cfg_fn]   = 1;
        end else begin
          m_cmp[cfg_fn] = cfg_data[31:8];
          m_am[cfg_fn]  = cfg_data[7:2];
          m_rl[cfg_fn]  = cfg_data[1];
          m_xam[cfg_fn] = cfg_data[0];
        end
      end
      m_asqq = m_asq;
      m_asq  = vme_as_n;
      m_addr = vme_addr;
      m_acc_am = vme_am;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [31:0] m_rd;
      chk("R5 per-clock fn_hit", 32'(fn_hit), 32'(m_hit));
      chk("R5 per-clock fn_sel", 32'(fn_sel), 32'(m_hit != 0));
      chk("R12 per-clock cfg_ready", 32'(cfg_ready), 32'(m_asq));
      m_rd = rd_reg_sel ? {m_mask[rd_fn], 5'b0, m_sz[rd_fn], 2'b0}
                        : {m_cmp[rd_fn], m_am[rd_fn], m_rl[rd_fn], m_xam[rd_fn]};
      chk("R7 per-clock rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic sel, input logic [1:0] fn, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1; cfg_reg_sel = sel; cfg_fn = fn; cfg_data = d;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic rd(input logic sel, input logic [1:0] fn, output logic [31:0] d);
    @(negedge clk);
    rd_reg_sel = sel; rd_fn = fn;
    #1 d = rd_data;
  endtask

  task automatic access(input logic [31:0] a, input logic [5:0] m);
    @(negedge clk);
    vme_as_n = 0; vme_addr = a; vme_am = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic release_as();
    vme_as_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [5:0] m,
                       input logic [3:0] exp);
    access(a, m);
    chk(tag, 32'(fn_hit), 32'(exp));
    release_as();
    chk({tag, " clear R6"}, 32'(fn_hit), 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 fn_sel after reset", 32'(fn_sel), 0);
    chk("R11 cfg_ready after reset", 32'(cfg_ready), 1);
    rd(0, 2'd1, d); chk("R11 compare word cleared", d, 0);

    wr(1, 0, 32'hFF00_0000);
    wr(0, 0, 32'h1200_0000 | (6'h0D << 2));
    wr(1, 1, 32'hFFF0_0000);
    wr(0, 1, 32'h1230_0000 | (6'h09 << 2));
    wr(1, 2, 32'h0000_0000);
    wr(0, 2, 32'h0000_0000 | (6'h0D << 2));
    wr(1, 3, 32'hFFFF_0005);
    wr(0, 3, 32'h5678_0000 | (6'h0D << 2));

    rd(1, 3, d); chk("R7 mask word readback, extra-decoder bit 0", d, 32'hFFFF_0004);

    // R1 timing: strobe low, hit appears on the second edge
    @(negedge clk);
    vme_as_n = 0; vme_addr = 32'h1234_5678; vme_am = 6'h0D;
    @(posedge clk); @(negedge clk);
    chk("R1 no hit after first edge", 32'(fn_hit), 0);
    @(posedge clk); @(negedge clk);
    chk("R1 hit after second edge", 32'(fn_hit), 32'h1);
    chk("R12 ready low during strobe", 32'(cfg_ready), 0);
    // R6 hold while address changes
    vme_addr = 32'h9900_0000;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R6 hold with address change", 32'(fn_hit), 32'h1);
    release_as();
    chk("R6 cleared after strobe high", 32'(fn_hit), 0);

    probe("R2 fn1 match by modifier", 32'h1234_5678, 6'h09, 4'b0010);
    probe("R2 no window matches", 32'h9900_0000, 6'h0D, 4'b0000);
    probe("R4 zero-mask window silent", 32'h0000_0000, 6'h0D, 4'b0000);
    probe("R2 fn3 match", 32'h5678_ABCD, 6'h0D, 4'b1000);
    probe("R3 modifier checked with sizing flag set", 32'h5678_ABCD, 6'h0E, 4'b0000);

    wr(0, 1, 32'h1230_0000 | (6'h0D << 2));
    probe("R5 lowest index wins", 32'h1234_5678, 6'h0D, 4'b0001);

    // R8 sizing reload on fn3
    wr(0, 3, 32'hFFFF_FF02);
    rd(1, 3, d); chk("R8 mask reloaded", d, 32'hFFFF_FF04);
    rd(0, 3, d); chk("R8 compare kept, reload flag set", d, 32'h5678_0036);
    probe("R8 window dark during reload", 32'h5678_ABCD, 6'h0D, 4'b0000);
    // R9 restore
    wr(0, 3, 32'h5678_0000 | (6'h0D << 2));
    rd(0, 3, d); chk("R9 compare restored", d, 32'h5678_0034);
    probe("R9 old address outside new mask", 32'h5678_ABCD, 6'h0D, 4'b0000);
    probe("R9 match under reloaded mask", 32'h5678_00CD, 6'h0D, 4'b1000);

    // R10 reload flag on a fixed-size window
    wr(0, 0, 32'h1200_0000 | (6'h0D << 2) | 32'h2);
    rd(0, 0, d); chk("R10 compare word stored", d, 32'h1200_0036);
    rd(1, 0, d); chk("R10 mask unchanged", d, 32'hFF00_0000);
    probe("R10 fn0 dark, fn1 wins", 32'h1234_5678, 6'h0D, 4'b0010);

    // R12 write held during a strobe
    access(32'h9900_0000, 6'h0D);
    cfg_valid = 1; cfg_reg_sel = 1; cfg_fn = 2; cfg_data = 32'hF000_0000;
    rd_reg_sel = 1; rd_fn = 2;
    repeat (2) @(negedge clk);
    chk("R12 ready low with write pending", 32'(cfg_ready), 0);
    chk("R12 write not taken during strobe", rd_data, 0);
    vme_as_n = 1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 0;
    #1 chk("R12 write taken after strobe", rd_data, 32'hF000_0000);

    // R11 reset again
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    rd(1, 3, d); chk("R11 mask cleared by reset", d, 0);
    chk("R11 hit cleared", 32'(fn_hit), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule